// File: doc/BRIEF.md
# Three-Wire Serial Timekeeping Register Slave

This block is the receiving end of a slow, software-driven three-wire link into a small always-on register file. The host drives a clock line, an enable line and a data line. The block drives a returned data line and a ready flag. Every line is resynchronised into the local clock domain, and only the rising edges of the link clock are acted upon. While enable is high, bits shift into a frame register. The next rising edge taken with enable low carries a direction bit. That bit either commits a write or starts a 32-bit read-back, and the read-back is clocked out one bit per further link-clock pulse.

The register file holds three kinds of word. The first is a free-running seconds counter, advanced by a one-cycle strobe once per second. The second is a plain adjust word. The third is a bank of four general-purpose retained words. A write frame carries its data word before the register address. A read frame carries only the address. The value to return is captured at the moment the direction bit is taken, so the counter keeps running during the read-back.

Top module: `rtcSerialSlave`

## Requirements
- R1: Frame bits are taken on rising edges of `sclkIn` while `senIn` is high, most significant bit first.
- R2: A read frame has 3 address bits with `senIn` high, then one rising edge with `senIn` low and `sdiIn` at 0. On each of the next 32 rising edges, `sdoOut` presents the next bit of the addressed word, most significant bit first. `sdoOut` changes only after a rising edge of `sclkIn`.
- R3: A write frame has 32 data bits followed by 3 address bits, all with `senIn` high. A rising edge with `senIn` low and `sdiIn` at 1 then stores the data word at that address.
- R4: Register addresses: 0 is the seconds counter, 2 is the adjust word, and 4, 5, 6 and 7 are the four retained words.
- R5: A read of address 1 or 3 returns zero, and a write to either address changes no register.
- R6: `readyOut` is 1 after reset and while idle. It goes to 0 when a read is committed and returns to 1 after the 32nd read-back bit.
- R7: The seconds counter increases by one for each clock cycle in which `ppsTick` is 1. It is zero after reset.
- R8: When a write to address 0 commits in the same cycle as a `ppsTick`, the counter takes the written value and is not incremented.
- R9: A rising edge of `senIn` discards any partly received frame, so a complete frame sent after an abandoned one is decoded correctly.
- R10: The read-back word is the value at the moment the direction bit is taken. Counter ticks during the read-back do not alter it.
- R11: A direction bit that follows a frame of the wrong length is ignored. A write needs exactly 35 bits before it and a read exactly 3: no register changes and no read-back starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ppsTick | input | 1 | One-cycle strobe, once per second, synchronous to clk |
| sclkIn | input | 1 | Link clock from the host, asynchronous |
| senIn | input | 1 | Link enable from the host, asynchronous |
| sdiIn | input | 1 | Link data from the host, asynchronous |
| sdoOut | output | 1 | Read-back data to the host |
| readyOut | output | 1 | High when a new transaction may begin |

## Verification
The hardest case to reach from the ports is a seconds tick that lands in the exact clock cycle in which a resynchronised direction bit commits a write to the counter. The bench places its strobe by counting the synchroniser and edge-detect registers from the moment it raises the link clock. It then reads the counter back and expects the written value, not that value plus one. A second stimulus ticks the counter in the middle of a read-back and checks that the word already being shifted out stays unchanged while the next read shows the increment. Abandoned partial frames and direction bits after frames of the wrong length are sent in between to show that only properly formed frames have any effect.

// File: rtl/rtcSerialPkg.sv
package rtcSerialPkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int FRAME_W   = DATA_W + ADDR_W;
  localparam int BIT_CNT_W = $clog2(FRAME_W + 1) + 1;
  localparam int OUT_CNT_W = $clog2(DATA_W + 1);
  localparam int SEC_ADDR  = 0;
  localparam int ADJ_ADDR  = 2;
  localparam int GP_BASE   = 4;
  localparam int GP_WORDS  = 4;
  localparam int GP_IDX_W  = (GP_WORDS > 1) ? $clog2(GP_WORDS) : 1;

  typedef enum logic {ST_IDLE, ST_SHIFT} linkState_t;

  typedef struct packed {
    logic clearFrame;
    logic capture;
    logic commitWr;
    logic commitRd;
    logic shiftOut;
  } ctlStrobes_t;
endpackage

// File: rtl/rtcLinkSync.sv
module rtcLinkSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] lvlOut,
  output logic [WIDTH-1:0] riseOut
);
  logic [STAGES*WIDTH-1:0] chain;
  logic [WIDTH-1:0]        prevLvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= rawIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[(STAGES-1)*WIDTH-1:0], rawIn};
      end
    end
  endgenerate

  assign lvlOut = chain[STAGES*WIDTH-1 -: WIDTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= lvlOut;
  end

  assign riseOut = lvlOut & ~prevLvl;
endmodule

// File: rtl/rtcLinkCtrl.sv
module rtcLinkCtrl
  import rtcSerialPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRise,
  input  logic        senRise,
  input  logic        senLvl,
  input  logic        sdiLvl,
  output ctlStrobes_t strobes,
  output logic        readyOut
);
  linkState_t           state;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [OUT_CNT_W-1:0] outLeft;
  logic                 dirEvt;

  always_comb begin
    dirEvt = sclkRise && !senLvl && !senRise && (state == ST_IDLE) && (bitCnt != '0);
    strobes.clearFrame = senRise;
    strobes.capture    = sclkRise && senLvl && !senRise && (state == ST_IDLE);
    strobes.commitWr   = dirEvt && sdiLvl && (bitCnt == BIT_CNT_W'(FRAME_W));
    strobes.commitRd   = dirEvt && !sdiLvl && (bitCnt == BIT_CNT_W'(ADDR_W));
    strobes.shiftOut   = sclkRise && !senRise && (state == ST_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      outLeft <= '0;
    end else if (senRise) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      outLeft <= '0;
    end else if (strobes.capture) begin
      if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
    end else if (dirEvt) begin
      bitCnt <= '0;
      if (strobes.commitRd) begin
        state   <= ST_SHIFT;
        outLeft <= OUT_CNT_W'(DATA_W);
      end
    end else if (strobes.shiftOut) begin
      outLeft <= outLeft - 1'b1;
      if (outLeft == OUT_CNT_W'(1)) state <= ST_IDLE;
    end
  end

  assign readyOut = (state == ST_IDLE);
endmodule

// File: rtl/rtcRegDatapath.sv
module rtcRegDatapath
  import rtcSerialPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ppsTick,
  input  logic              sdiLvl,
  input  ctlStrobes_t       strobes,
  output logic              sdoOut,
  output logic [DATA_W-1:0] secValue
);
  logic [FRAME_W-1:0] inShift;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  wrData;
  logic [DATA_W-1:0]  secCount;
  logic [DATA_W-1:0]  adjWord;
  logic [DATA_W-1:0]  gpWord [GP_WORDS];
  logic [DATA_W-1:0]  rdData;
  logic [DATA_W-1:0]  outShift;
  logic [GP_IDX_W-1:0] gpIdx;

  assign addr   = inShift[ADDR_W-1:0];
  assign wrData = inShift[FRAME_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   inShift <= '0;
    else if (strobes.clearFrame) inShift <= '0;
    else if (strobes.capture)    inShift <= {inShift[FRAME_W-2:0], sdiLvl};
  end

  // write load outranks the per-second increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                                    secCount <= '0;
    else if (strobes.commitWr && addr == ADDR_W'(SEC_ADDR))       secCount <= wrData;
    else if (ppsTick)                                             secCount <= secCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                               adjWord <= '0;
    else if (strobes.commitWr && addr == ADDR_W'(ADJ_ADDR))  adjWord <= wrData;
  end

  generate
    for (genvar i = 0; i < GP_WORDS; i++) begin : g_gp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                                gpWord[i] <= '0;
        else if (strobes.commitWr && addr == ADDR_W'(GP_BASE + i)) gpWord[i] <= wrData;
      end
    end
  endgenerate

  assign gpIdx = GP_IDX_W'(addr - ADDR_W'(GP_BASE));

  always_comb begin
    if (addr == ADDR_W'(SEC_ADDR))                                   rdData = secCount;
    else if (addr == ADDR_W'(ADJ_ADDR))                              rdData = adjWord;
    else if (int'(addr) >= GP_BASE && int'(addr) < GP_BASE + GP_WORDS) rdData = gpWord[gpIdx];
    else                                                             rdData = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      sdoOut   <= 1'b0;
    end else if (strobes.commitRd) begin
      outShift <= rdData;
    end else if (strobes.shiftOut) begin
      sdoOut   <= outShift[DATA_W-1];
      outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  assign secValue = secCount;
endmodule

// File: rtl/rtcSerialSlave.sv
module rtcSerialSlave
  import rtcSerialPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ppsTick,
  input  logic sclkIn,
  input  logic senIn,
  input  logic sdiIn,
  output logic sdoOut,
  output logic readyOut
);
  logic [2:0]        lineLvl;
  logic [2:0]        lineRise;
  logic              sclkRise;
  logic              senRise;
  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] secValue;

  rtcLinkSync #(.STAGES(SYNC_STAGES), .WIDTH(3)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({sdiIn, senIn, sclkIn}),
    .lvlOut (lineLvl),
    .riseOut(lineRise)
  );

  assign sclkRise = lineRise[0];
  assign senRise  = lineRise[1];

  rtcLinkCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclkRise(sclkRise),
    .senRise (senRise),
    .senLvl  (lineLvl[1]),
    .sdiLvl  (lineLvl[2]),
    .strobes (strobes),
    .readyOut(readyOut)
  );

  rtcRegDatapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ppsTick (ppsTick),
    .sdiLvl  (lineLvl[2]),
    .strobes (strobes),
    .sdoOut  (sdoOut),
    .secValue(secValue)
  );
endmodule

// File: rtl/rtcSerialSlaveChk.sv
module rtcSerialSlaveChk
  import rtcSerialPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ppsTick,
  input logic              readyOut,
  input logic              sdoOut,
  input logic              sclkRise,
  input logic              senRise,
  input ctlStrobes_t       strobes,
  input logic [DATA_W-1:0] secValue
);
  // R2: returned data moves only on a link-clock rising edge
  assert_sdo_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sclkRise |=> $stable(sdoOut));

  // R3: commit, read start and shift are never taken together
  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.commitWr, strobes.commitRd, strobes.shiftOut}));

  // R6: ready drops only when a read has been committed
  assert_ready_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> $past(strobes.commitRd));

  // R6: ready returns only after a link-clock edge or an enable rise
  assert_ready_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> ($past(sclkRise) || $past(senRise)));

  // R7: a tick without a write advances the counter by one
  assert_tick_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ppsTick && !strobes.commitWr) |=> secValue == DATA_W'($past(secValue) + 1));

  // R7: no tick and no write leaves the counter alone
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ppsTick && !strobes.commitWr) |=> $stable(secValue));
endmodule

bind rtcSerialSlave rtcSerialSlaveChk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .ppsTick (ppsTick),
  .readyOut(readyOut),
  .sdoOut  (sdoOut),
  .sclkRise(sclkRise),
  .senRise (senRise),
  .strobes (strobes),
  .secValue(secValue)
);

// File: tb/rtcSerialSlave_tb_top.sv
module rtcSerialSlave_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ppsTick = 1'b0;
  logic sclk = 1'b0;
  logic sen = 1'b0;
  logic sdi = 1'b0;
  logic sdoOut;
  logic readyOut;

  int checks = 0;
  int errs = 0;
  bit settled = 1'b0;

  // behavioural reference model
  logic [31:0] mreg [8];
  bit          frameQ [$];
  logic [31:0] expWord;
  int          shiftLeft = 0;
  logic        expSdo = 1'b0;
  logic        expReady = 1'b1;

  always #5 clk = ~clk;

  rtcSerialSlave dut_i (
    .clk(clk), .rstN(rstN), .ppsTick(ppsTick), .sclkIn(sclk),
    .senIn(sen), .sdiIn(sdi), .sdoOut(sdoOut), .readyOut(readyOut)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(int a);
    if (a == 1 || a == 3) return 32'h0;
    return mreg[a];
  endfunction

  task automatic modelEdge();
    if (shiftLeft > 0) begin
      shiftLeft--;
      expSdo = expWord[shiftLeft];
      if (shiftLeft == 0) expReady = 1'b1;
    end else if (sen) begin
      frameQ.push_back(sdi);
    end else begin
      if (frameQ.size() == 35 && sdi) begin
        logic [31:0] d = '0;
        int a = 0;
        for (int i = 0; i < 32; i++) d = {d[30:0], frameQ[i]};
        for (int i = 32; i < 35; i++) a = a * 2 + int'(frameQ[i]);
        if (a != 1 && a != 3) mreg[a] = d;
      end else if (frameQ.size() == 3 && !sdi) begin
        int a = 0;
        for (int i = 0; i < 3; i++) a = a * 2 + int'(frameQ[i]);
        expWord = modelRead(a);
        shiftLeft = 32;
        expReady = 1'b0;
      end
      frameQ.delete();
    end
  endtask

  // compare against the model on every clock once the link has settled
  always @(posedge clk) begin
    #2;
    if (settled && rstN) begin
      chk("R2 sdo per-clock", {31'b0, sdoOut}, {31'b0, expSdo});
      chk("R6 ready per-clock", {31'b0, readyOut}, {31'b0, expReady});
    end
  end

  // collide=1 places a tick on the cycle the synchronised edge is acted on
  task automatic sclkLevel(bit v, bit collide);
    @(negedge clk) sclk = v; settled = 1'b0;
    @(negedge clk);
    @(negedge clk) if (collide) ppsTick = 1'b1;
    @(negedge clk) ppsTick = 1'b0;
    @(negedge clk);
    if (v) modelEdge();
    settled = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic setSen(bit v);
    @(negedge clk) sen = v;
    if (v) frameQ.delete();
    repeat (6) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    @(negedge clk) sdi = b;
    sclkLevel(1'b0, 1'b0);
    sclkLevel(1'b1, 1'b0);
  endtask

  task automatic ppsPulse();
    @(negedge clk) ppsTick = 1'b1;
    @(negedge clk) ppsTick = 1'b0;
    mreg[0] = mreg[0] + 1;
  endtask

  task automatic rawFrame(logic [34:0] bits, int n, bit dir, bit collide);
    setSen(1'b1);
    for (int i = n - 1; i >= 0; i--) sendBit(bits[i]);
    setSen(1'b0);
    @(negedge clk) sdi = dir;
    sclkLevel(1'b0, 1'b0);
    sclkLevel(1'b1, collide);
    @(negedge clk) sdi = 1'b0;
  endtask

  task automatic writeWord(int a, logic [31:0] d, bit collide);
    rawFrame({d, 3'(a)}, 35, 1'b1, collide);
  endtask

  task automatic readWord(int a, bit ppsMid, output logic [31:0] w);
    w = '0;
    rawFrame({32'b0, 3'(a)}, 3, 1'b0, 1'b0);
    chk("R6 ready low after read commit", {31'b0, readyOut}, 32'h0);
    for (int i = 0; i < 32; i++) begin
      sclkLevel(1'b0, 1'b0);
      sclkLevel(1'b1, 1'b0);
      w = {w[30:0], sdoOut};
      if (ppsMid && i == 0) ppsPulse();
    end
    chk("R6 ready back after 32 bits", {31'b0, readyOut}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] w;
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 ready after reset", {31'b0, readyOut}, 32'h1);
    chk("R2 sdo after reset", {31'b0, sdoOut}, 32'h0);
    settled = 1'b1;

    readWord(0, 1'b0, w);
    chk("R7 counter zero after reset", w, 32'h0);

    // R1 R3 R4: retained words
    writeWord(4, 32'hDEADBEEF, 1'b0);
    writeWord(5, 32'h01234567, 1'b0);
    writeWord(6, 32'h80000001, 1'b0);
    writeWord(7, 32'hFFFFFFFF, 1'b0);
    readWord(4, 1'b0, w); chk("R3 word 4", w, 32'hDEADBEEF);
    readWord(5, 1'b0, w); chk("R1 word 5 bit order", w, 32'h01234567);
    readWord(6, 1'b0, w); chk("R4 word 6", w, 32'h80000001);
    readWord(7, 1'b0, w); chk("R4 word 7", w, 32'hFFFFFFFF);

    writeWord(2, 32'hCAFEF00D, 1'b0);
    readWord(2, 1'b0, w); chk("R4 adjust word", w, 32'hCAFEF00D);

    // R5: unmapped holes
    writeWord(1, 32'h11111111, 1'b0);
    writeWord(3, 32'h33333333, 1'b0);
    readWord(1, 1'b0, w); chk("R5 addr 1 reads zero", w, 32'h0);
    readWord(3, 1'b0, w); chk("R5 addr 3 reads zero", w, 32'h0);
    readWord(2, 1'b0, w); chk("R5 adjust untouched", w, 32'hCAFEF00D);
    readWord(4, 1'b0, w); chk("R5 word 4 untouched", w, 32'hDEADBEEF);

    // R7: ticking
    writeWord(0, 32'd100, 1'b0);
    ppsPulse(); ppsPulse(); ppsPulse();
    readWord(0, 1'b0, w); chk("R7 counter after 3 ticks", w, 32'd103);

    // R8: tick in the commit cycle
    writeWord(0, 32'h00000055, 1'b1);
    readWord(0, 1'b0, w); chk("R8 load beats tick", w, 32'h00000055);

    // R10: tick during read-back
    readWord(0, 1'b1, w); chk("R10 latched word", w, 32'h00000055);
    readWord(0, 1'b0, w); chk("R10 tick landed", w, 32'h00000056);

    // R9: abandoned partial frame
    setSen(1'b1);
    for (int i = 0; i < 10; i++) sendBit(bit'(i & 1));
    setSen(1'b0);
    writeWord(5, 32'hA5A55A5A, 1'b0);
    readWord(5, 1'b0, w); chk("R9 frame after abort", w, 32'hA5A55A5A);

    // R11: wrong-length frames
    rawFrame({32'b0, 3'd6}, 3, 1'b1, 1'b0);
    readWord(6, 1'b0, w); chk("R11 short write ignored", w, 32'h80000001);
    rawFrame({32'h12345678, 3'd7}, 35, 1'b0, 1'b0);
    chk("R11 long read ignored", {31'b0, readyOut}, 32'h1);
    readWord(7, 1'b0, w); chk("R11 word 7 untouched", w, 32'hFFFFFFFF);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule